// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block sits on a two-wire serial bus running at up to 400 kHz and holds twelve 8-bit configuration locations for a lamp-driver controller. A system clock samples the bus clock and data lines through short synchronisers. The block drives the data line only by pulling it low, and the chip's pad turns that enable into an open-drain output. Two strap pins set the two low bits of the 7-bit bus address. The other five bits are fixed at `11110`. An active-low reset pin clears every location, and while it is low the block ignores the bus.

The master sends the address with the direction bit low, then a pointer byte, then any number of data bytes. Each data byte lands at the pointer, and the pointer then advances. To read, the master sends the address with the direction bit high. A read that begins after a STOP, or after reset, starts at location 0. A repeated START that follows a pointer write reads from that pointer instead. In both directions the pointer saturates at the last location and does not wrap. Location 10 is not storage: writing it gives a one-cycle apply strobe, and on that strobe the four peak/ramp locations 6 to 9 are copied into a shadow output for the lamp stage. Location 0 is a fixed identity byte. Bit 7 of location 1 is a sticky over-temperature flag.

The bus carries no back-pressure. The block never stretches the clock, so every byte is accepted or answered in the bit time the master gives it. All configuration pins are plain levels and strobes.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges by pulling SDA low for the whole ninth clock of an address byte whose upper five bits are `11110` and whose next two bits equal `strap_i[1:0]`. Any other address gets no acknowledge, and the rest of that frame is ignored.
- R2: In a write frame the first byte after the address loads the pointer. Each later byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R3: A pointer byte above 11 loads 11. Advancing from 11, on a write or on a read, stays at 11.
- R4: A read that follows a STOP or reset starts at location 0. A read after a repeated START that follows a pointer write starts at that pointer. The pointer advances after each byte sent.
- R5: In a read, a master NACK releases SDA, and the block drives nothing more until the next START.
- R6: After reset, location 0 reads 0xB2 and every other location reads 0x00. Writes to location 0 are dropped, but they still advance the pointer.
- R7: A write to location 10 gives exactly one `apply_o` pulse of one cycle. In the same cycle `shadow_o` captures locations 6..9, with location 6 in bits 7:0 and location 9 in bits 31:24. Location 10 always reads 0x00, and `shadow_o` changes at no other time.
- R8: While `rst_n` is low, all locations and the over-temperature flag are cleared and the block never pulls SDA low.
- R9: A STOP (SDA rising while SCL is high) ends any frame at any bit and returns the pointer to 0. A partly received byte is not stored. The exception is a STOP inside the same SCL high period as a START, which is ignored.
- R10: Location 1 bit 7 is set by `overtemp_i` and stays set until `rst_n` goes low. Bus writes cannot change it. Bits 6:0 of location 1 are ordinary storage.
- R11: SDA is sampled on the rising edge of SCL. The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; clears the block and mutes it on the bus |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| strap_i | input | 2 | Low two bits of the 7-bit bus address |
| overtemp_i | input | 1 | Over-temperature event; sets the sticky flag |
| regs_o | output | 96 | Current contents of all locations, location n in bits 8n+7:8n |
| apply_o | output | 1 | One-cycle strobe when location 10 is written |
| shadow_o | output | 32 | Peak/ramp settings captured at the last apply |

## Verification
Two functions can land in the same system-clock cycle. One is the over-temperature latch, driven from `overtemp_i`. The other is a bus write to location 1, which stores the data byte on the SCL fall after its eighth bit. The bench holds `overtemp_i` high for the whole of a data byte aimed at location 1, so the flag set and the store must overlap. A correct result reads back as the flag set together with the new low seven bits, and the reference model is compared on every clock around it. The apply strobe and the shadow capture also share a cycle. That case is judged by counting strobes and comparing `shadow_o` against the model on every clock.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } link_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } rx_phase_t;

  localparam logic [4:0] ADDR_FIXED = 5'b11110;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o,
  output logic [LINES-1:0] prev_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain  <= '1;
        prev_q <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], d_i[g]};
        prev_q <= chain[STAGES-1];
      end
    end

    assign q_o[g]    = chain[STAGES-1];
    assign prev_o[g] = prev_q;
  end

endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
  import i2cs_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int PW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_q,
  input  logic          scl_p,
  input  logic          sda_q,
  input  logic          sda_p,
  input  logic [1:0]    strap,
  input  logic [7:0]    rd_data,
  output logic [PW-1:0] rd_addr,
  output logic          wr_en,
  output logic [PW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);

  localparam int LAST = NUM_REGS - 1;

  link_state_t state_q;
  rx_phase_t   phase_q;
  logic [3:0]  bitcnt_q;
  logic [7:0]  sh_q;
  logic [PW-1:0] ptr_q;
  logic        rw_q;
  logic        sda_oe_q;
  logic        start_seen_q;
  logic        wr_en_q;
  logic [PW-1:0] wr_addr_q;
  logic [7:0]  wr_data_q;

  logic scl_rise, scl_fall, start_ev, stop_raw, stop_ev;

  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  assign start_ev = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_raw = scl_q & scl_p & ~sda_p & sda_q;
  assign stop_ev  = stop_raw & ~start_seen_q;

  function automatic logic [PW-1:0] sat_inc(input logic [PW-1:0] p);
    return (p == PW'(LAST)) ? p : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      phase_q      <= PH_ADDR;
      bitcnt_q     <= '0;
      sh_q         <= '0;
      ptr_q        <= '0;
      rw_q         <= 1'b0;
      sda_oe_q     <= 1'b0;
      start_seen_q <= 1'b0;
      wr_en_q      <= 1'b0;
      wr_addr_q    <= '0;
      wr_data_q    <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_ev)      start_seen_q <= 1'b1;
      else if (scl_fall) start_seen_q <= 1'b0;

      if (start_ev) begin
        state_q  <= ST_RX;
        phase_q  <= PH_ADDR;
        bitcnt_q <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_ev) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
        ptr_q    <= '0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise && bitcnt_q != 4'd8) begin
              sh_q     <= {sh_q[6:0], sda_q};
              bitcnt_q <= bitcnt_q + 4'd1;
            end else if (scl_fall && bitcnt_q == 4'd8) begin
              case (phase_q)
                PH_ADDR: begin
                  if (sh_q[7:1] == {ADDR_FIXED, strap}) begin
                    rw_q     <= sh_q[0];
                    sda_oe_q <= 1'b1;
                    state_q  <= ST_RXACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                PH_PTR: begin
                  ptr_q    <= (sh_q > 8'(LAST)) ? PW'(LAST) : sh_q[PW-1:0];
                  sda_oe_q <= 1'b1;
                  state_q  <= ST_RXACK;
                end
                default: begin
                  wr_en_q   <= 1'b1;
                  wr_addr_q <= ptr_q;
                  wr_data_q <= sh_q;
                  ptr_q     <= sat_inc(ptr_q);
                  sda_oe_q  <= 1'b1;
                  state_q   <= ST_RXACK;
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (phase_q == PH_ADDR && rw_q) begin
                state_q  <= ST_TX;
                sh_q     <= rd_data;
                sda_oe_q <= ~rd_data[7];
                ptr_q    <= sat_inc(ptr_q);
              end else begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_RX;
                phase_q  <= (phase_q == PH_ADDR) ? PH_PTR : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt_q == 4'd7) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_TXACK;
                bitcnt_q <= '0;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_q <= ~sh_q[6];
                bitcnt_q <= bitcnt_q + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise && sda_q) begin
              state_q <= ST_IDLE;
            end else if (scl_fall) begin
              sh_q     <= rd_data;
              sda_oe_q <= ~rd_data[7];
              ptr_q    <= sat_inc(ptr_q);
              state_q  <= ST_TX;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_addr = ptr_q;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign sda_oe  = sda_oe_q;

  // R11: drive changes only after SCL was seen low, or on a bus condition
  p_sda_moves_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_q) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe_q));

  // R5: nothing is driven once the link has gone idle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_q);

  // R3: the pointer never leaves the location range
  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PW'(LAST));

  // R9: an honoured STOP leaves the pointer at zero
  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (ptr_q == '0));

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
  parameter int          NUM_REGS     = 12,
  parameter int          PW           = 4,
  parameter int          CMD_ADDR     = 10,
  parameter logic [7:0]  ID_VALUE     = 8'hB2,
  parameter int          SHADOW_FIRST = 6,
  parameter int          SHADOW_COUNT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PW-1:0]             wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [PW-1:0]             rd_addr,
  output logic [7:0]                rd_data,
  input  logic                      ovt_i,
  output logic [NUM_REGS*8-1:0]     regs_o,
  output logic                      apply_o,
  output logic [SHADOW_COUNT*8-1:0] shadow_o
);

  logic [NUM_REGS*8-1:0]     flat;
  logic                      ovt_q;
  logic                      apply_q;
  logic [SHADOW_COUNT*8-1:0] shadow_q;
  logic                      cmd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ovt_q <= 1'b0;
    else if (ovt_i) ovt_q <= 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_loc
    if (i == 0) begin : g_id
      assign flat[7:0] = ID_VALUE;
    end else if (i == CMD_ADDR) begin : g_cmd
      assign flat[i*8 +: 8] = 8'h00;
    end else if (i == 1) begin : g_stat
      logic [6:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en && wr_addr == PW'(i)) q <= wr_data[6:0];
      end
      assign flat[15:8] = {ovt_q, q};
    end else begin : g_plain
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en && wr_addr == PW'(i)) q <= wr_data;
      end
      assign flat[i*8 +: 8] = q;
    end
  end

  assign cmd_hit = wr_en && (wr_addr == PW'(CMD_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apply_q  <= 1'b0;
      shadow_q <= '0;
    end else begin
      apply_q <= cmd_hit;
      if (cmd_hit) shadow_q <= flat[SHADOW_FIRST*8 +: SHADOW_COUNT*8];
    end
  end

  assign rd_data  = (int'(rd_addr) < NUM_REGS) ? flat[int'(rd_addr)*8 +: 8] : 8'h00;
  assign regs_o   = flat;
  assign apply_o  = apply_q;
  assign shadow_o = shadow_q;

  // R7: the apply strobe never lasts two cycles
  p_apply_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    apply_q |=> !apply_q);

  // R10: once set, the flag holds until reset
  p_ovt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovt_q) |-> ovt_q);

  // R7: the shadow only moves together with the strobe
  p_shadow_on_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shadow_q) |-> apply_q);

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter int         NUM_REGS     = 12,
  parameter int         CMD_ADDR     = 10,
  parameter logic [7:0] ID_VALUE     = 8'hB2,
  parameter int         SHADOW_FIRST = 6,
  parameter int         SHADOW_COUNT = 4,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe_o,
  input  logic [1:0]                strap_i,
  input  logic                      overtemp_i,
  output logic [NUM_REGS*8-1:0]     regs_o,
  output logic                      apply_o,
  output logic [SHADOW_COUNT*8-1:0] shadow_o
);

  localparam int PW = $clog2(NUM_REGS);

  logic [1:0]    line_q, line_p;
  logic [7:0]    rd_data;
  logic [PW-1:0] rd_addr;
  logic          wr_en;
  logic [PW-1:0] wr_addr;
  logic [7:0]    wr_data;

  i2cs_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({sda_i, scl_i}),
    .q_o    (line_q),
    .prev_o (line_p)
  );

  i2cs_link #(.NUM_REGS(NUM_REGS), .PW(PW)) u_link (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_q   (line_q[0]),
    .scl_p   (line_p[0]),
    .sda_q   (line_q[1]),
    .sda_p   (line_p[1]),
    .strap   (strap_i),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sda_oe  (sda_oe_o)
  );

  i2cs_regs #(
    .NUM_REGS     (NUM_REGS),
    .PW           (PW),
    .CMD_ADDR     (CMD_ADDR),
    .ID_VALUE     (ID_VALUE),
    .SHADOW_FIRST (SHADOW_FIRST),
    .SHADOW_COUNT (SHADOW_COUNT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ovt_i    (overtemp_i),
    .regs_o   (regs_o),
    .apply_o  (apply_o),
    .shadow_o (shadow_o)
  );

endmodule

// File: tb/i2c_regslave_tb.sv
`timescale 1ns/1ps
module i2c_regslave_tb;

  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [1:0]  strap = 2'b01;
  logic        overtemp = 1'b0;
  logic        sda_oe;
  logic [95:0] regs;
  logic        apply;
  logic [31:0] shadow;
  logic        sda_line;

  assign sda_line = m_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regslave u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .strap_i    (strap),
    .overtemp_i (overtemp),
    .regs_o     (regs),
    .apply_o    (apply),
    .shadow_o   (shadow)
  );

  int  vectors = 0;
  int  fails = 0;
  int  mreg [12];
  int  mshadow [4];
  bit  movt = 0;
  int  mptr = 0;
  int  apply_exp = 0;
  int  apply_seen = 0;
  bit  hold_cmp = 1'b1;
  bit  done = 1'b0;
  bit  prev_scl = 1'b1;
  bit  prev_oe = 1'b0;
  byte unsigned wq[$];

  function automatic int mview(int i);
    if (i == 0) return 'hB2;
    if (i == 1) return (movt ? 128 : 0) | (mreg[1] & 127);
    if (i == 10) return 0;
    return mreg[i];
  endfunction

  function automatic void mclear();
    for (int i = 0; i < 12; i++) mreg[i] = 0;
    for (int i = 0; i < 4; i++) mshadow[i] = 0;
    movt = 0;
    mptr = 0;
  endfunction

  function automatic void mwrite(int a, int d);
    if (a == 10) begin
      apply_exp++;
      for (int i = 0; i < 4; i++) mshadow[i] = mreg[6 + i];
    end else if (a != 0) begin
      mreg[a] = d;
    end
  endfunction

  function automatic int sat(int p);
    return (p >= 11) ? 11 : p + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  // Reference model compared on every clock (R6, R2, R7, R10)
  always @(negedge clk) begin
    if (rst_n && !hold_cmp && !done) begin
      bit bad = 0;
      int bi = 0;
      int bg = 0;
      int be = 0;
      for (int i = 0; i < 12; i++)
        if (int'(regs[i*8 +: 8]) != mview(i)) begin
          bad = 1; bi = i; bg = int'(regs[i*8 +: 8]); be = mview(i);
        end
      for (int i = 0; i < 4; i++)
        if (int'(shadow[i*8 +: 8]) != mshadow[i]) begin
          bad = 1; bi = 100 + i; bg = int'(shadow[i*8 +: 8]); be = mshadow[i];
        end
      vectors++;
      if (bad) begin
        fails++;
        $display("FAIL R6/R7 location %0d got %0h exp %0h", bi, bg, be);
      end
    end
    if (apply) apply_seen++;
    // R11: drive changes only while SCL is low
    if (rst_n && m_scl && prev_scl && (sda_oe != prev_oe))
      chk(1'b0, "R11 sda drive moved with SCL high", int'(sda_oe), int'(prev_oe));
    prev_scl = m_scl;
    prev_oe  = sda_oe;
  end

  task automatic wait_t(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; wait_t(T);
    m_scl = 1; wait_t(T);
    m_sda = 0; wait_t(T);
    m_scl = 0; wait_t(T);
  endtask

  task automatic bus_stop();
    m_sda = 0; wait_t(T);
    m_scl = 1; wait_t(T);
    m_sda = 1; wait_t(T);
    mptr = 0;
  endtask

  task automatic send_bit(input bit b);
    m_sda = b; wait_t(T);
    m_scl = 1; wait_t(2 * T);
    m_scl = 0; wait_t(T);
  endtask

  task automatic recv_bit(output bit b);
    m_sda = 1; wait_t(T);
    m_scl = 1; wait_t(T);
    b = sda_line; wait_t(T);
    m_scl = 0; wait_t(T);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit nb;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(nb);
    ack = !nb;
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(last);
  endtask

  task automatic write_frame(input int ptr, input bit with_stop);
    bit ack;
    bus_start();
    send_byte({5'b11110, strap, 1'b0}, ack);
    chk(ack, "R1 address ack (write)", int'(ack), 1);
    send_byte(8'(ptr), ack);
    chk(ack, "R2 pointer ack", int'(ack), 1);
    mptr = (ptr > 11) ? 11 : ptr;
    foreach (wq[k]) begin
      hold_cmp = 1;
      send_byte(wq[k], ack);
      chk(ack, "R2 data ack", int'(ack), 1);
      mwrite(mptr, int'(wq[k]));
      mptr = sat(mptr);
      hold_cmp = 0;
    end
    wq.delete();
    if (with_stop) bus_stop();
  endtask

  task automatic read_frame(input int n, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({5'b11110, strap, 1'b1}, ack);
    chk(ack, "R1 address ack (read)", int'(ack), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, d);
      chk(int'(d) == mview(mptr), req, int'(d), mview(mptr));
      mptr = sat(mptr);
    end
    chk(sda_oe == 1'b0, "R5 released after NACK", int'(sda_oe), 0);
    bus_stop();
  endtask

  initial begin
    bit ack;
    mclear();
    wait_t(6);
    rst_n = 1;
    wait_t(4);
    hold_cmp = 0;
    // R6 reset state
    chk(sda_oe == 0 && apply == 0, "R6 idle outputs after reset", int'({sda_oe, apply}), 0);
    chk(int'(regs[7:0]) == 'hB2, "R6 identity location", int'(regs[7:0]), 'hB2);

    // R4 read from idle starts at 0
    read_frame(3, "R4 read after idle starts at 0");

    // R2, R6: write across location 0 (dropped) into 1..3
    wq.push_back(8'h33); wq.push_back(8'h15); wq.push_back(8'hC4); wq.push_back(8'h5E);
    write_frame(0, 1);
    read_frame(4, "R2 autoincrement write readback");

    // R4 repeated START after pointer write reads from pointer
    write_frame(2, 0);
    read_frame(3, "R4 read from preset pointer");

    // R7 apply with shadow capture
    wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33); wq.push_back(8'h44);
    wq.push_back(8'h5A);
    write_frame(6, 1);
    wait_t(2);
    chk(apply_seen == apply_exp, "R7 apply pulse count", apply_seen, apply_exp);

    // R3 saturation on write and read
    wq.push_back(8'hA1); wq.push_back(8'hA2); wq.push_back(8'hA3); wq.push_back(8'hA4);
    write_frame(9, 1);
    write_frame(10, 0);
    read_frame(3, "R3 R7 read saturates, command location reads 0");
    wq.push_back(8'h5C);
    write_frame(8'h40, 1);
    read_frame(12, "R3 full sweep to last location");
    chk(apply_seen == apply_exp, "R7 apply pulse count after saturation", apply_seen, apply_exp);

    // R1 wrong address is ignored
    bus_start();
    send_byte({5'b11110, 2'b10, 1'b0}, ack);
    chk(!ack, "R1 foreign address not acked", int'(ack), 0);
    send_byte(8'h04, ack);
    chk(!ack, "R1 foreign frame stays silent", int'(ack), 0);
    bus_stop();
    strap = 2'b10;
    wq.push_back(8'h9D);
    write_frame(4, 1);
    read_frame(5, "R1 new strap address");
    strap = 2'b01;

    // R9 STOP mid byte drops the partial data
    bus_start();
    send_byte({5'b11110, strap, 1'b0}, ack);
    send_byte(8'h04, ack);
    send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    bus_stop();
    read_frame(5, "R9 partial byte not stored");

    // R9 STOP inside the START high period is ignored
    m_sda = 1; wait_t(T);
    m_scl = 1; wait_t(T);
    m_sda = 0; wait_t(T);
    m_sda = 1; wait_t(T);
    m_sda = 0; wait_t(T);
    m_scl = 0; wait_t(T);
    send_byte({5'b11110, strap, 1'b0}, ack);
    chk(ack, "R9 START survives same-period STOP", int'(ack), 1);
    send_byte(8'h05, ack);
    hold_cmp = 1;
    send_byte(8'h77, ack);
    mwrite(5, 'h77);
    hold_cmp = 0;
    bus_stop();
    read_frame(6, "R9 frame after ignored STOP");

    // R10 overtemp set in the same window as a write to location 1
    bus_start();
    send_byte({5'b11110, strap, 1'b0}, ack);
    send_byte(8'h01, ack);
    hold_cmp = 1;
    overtemp = 1;
    send_byte(8'h15, ack);
    overtemp = 0;
    movt = 1;
    mwrite(1, 'h15);
    hold_cmp = 0;
    bus_stop();
    read_frame(2, "R10 flag and write in same window");
    wq.push_back(8'h00);
    write_frame(1, 1);
    read_frame(2, "R10 flag survives write of zero");

    // R8 reset clears and mutes the block
    hold_cmp = 1;
    rst_n = 0;
    mclear();
    wait_t(2);
    bus_start();
    send_byte({5'b11110, strap, 1'b0}, ack);
    chk(!ack, "R8 no ack during reset", int'(ack), 0);
    bus_stop();
    chk(int'(regs[15:8]) == 0, "R8 flag cleared by reset", int'(regs[15:8]), 0);
    rst_n = 1;
    wait_t(4);
    hold_cmp = 0;
    read_frame(12, "R8 all locations back to reset values");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      vectors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule